// File: doc/BRIEF.md
# Cluster Wait-State and Event Unit

This block keeps track of the low-power wait states for a small cluster of cores. A core can stop and wait for an interrupt, or it can stop and wait for an event. On entry the block drops the core's clock enable and raises the matching standby flag. Snoop, maintenance or debug-register traffic aimed at a sleeping core turns its clock enable back on for as long as that traffic is present. The standby flag stays up during that time and the core stays in its wait state. Clock gating is modelled only as enable outputs.

Three sources produce an event that reaches every core at the same time: a send-event from any running core, a cycle with the external event input high, and the start of a monitor-clear request. Each core has a one-bit pending-event flag. An event that wakes a core in event-wait is consumed by that wake. An event that reaches a running core, or a core in interrupt-wait, is stored in the flag. A later event-wait request that finds the flag set clears the flag and returns at once. A send-event also drives a cluster event output high for a fixed number of cycles. The monitor-clear request is answered on a four-phase request/acknowledge pair.

Top module: `cluster_evt_unit`

## Requirements
- R1: After reset every core is running. All standby flags are 0, all clock enables are 1, and `event_out` and `mon_clr_ack` are 0.
- R2: A running core that raises `wfi_req` shows `standby_wfi` set from the next cycle and its clock enable drops. If `wfi_req` and `wfe_req` are both high in the same cycle, interrupt-wait is taken.
- R3: A running core that raises `wfe_req` while its pending-event flag is clear, and with no broadcast event in that cycle, shows `standby_wfe` set from the next cycle. If the flag is set or a broadcast event arrives in that cycle, the core stays running and the flag is cleared.
- R4: While any of `snoop_req`, `maint_req` or `dbg_req` is high for a core, that core's `core_clk_en` is 1 in the same cycle, and its standby flag and wait state do not change.
- R5: A core in event-wait returns to running in the next cycle when any of these is high: a broadcast event, its `local_wake`, or its `irq_wake`. A broadcast event that wakes the core is consumed and does not set its flag.
- R6: A core in interrupt-wait leaves only on reset or `irq_wake`. Broadcast events and `local_wake` do not wake it.
- R7: A send-event from a running core drives `event_out` high for exactly 3 cycles, starting with the next cycle. A new send-event during the pulse restarts the count of 3. `event_in` and monitor-clear requests do not drive `event_out`.
- R8: `mon_clr_ack` follows `mon_clr_req` one cycle later, both when it rises and when it falls. The cycle in which the request is high and the acknowledge is still low is one broadcast event.
- R9: `wfi_req`, `wfe_req` and `sev_req` from a core that is in a standby state are ignored.
- R10: A broadcast event sets the pending-event flag of every core that is running or in interrupt-wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfi_req | input | N_CORES | Per-core request to enter interrupt-wait |
| wfe_req | input | N_CORES | Per-core request to enter event-wait |
| sev_req | input | N_CORES | Per-core send-event |
| irq_wake | input | N_CORES | Per-core interrupt-class wake, exits either wait state |
| local_wake | input | N_CORES | Per-core local wake, exits event-wait only |
| snoop_req | input | N_CORES | Per-core snoop needing the core's data cache |
| maint_req | input | N_CORES | Per-core cache, translation or predictor maintenance |
| dbg_req | input | N_CORES | Per-core debug or trace register access |
| event_in | input | 1 | External event, broadcast to all cores |
| mon_clr_req | input | 1 | Monitor-clear request, four-phase |
| core_clk_en | output | N_CORES | Per-core clock enable |
| standby_wfi | output | N_CORES | Per-core interrupt-wait flag |
| standby_wfe | output | N_CORES | Per-core event-wait flag |
| event_out | output | 1 | Cluster event pulse after a send-event |
| mon_clr_ack | output | 1 | Monitor-clear acknowledge |

## Verification
The handshake checker assumes that the agent driving `mon_clr_req` keeps the request high until the acknowledge has risen. It also assumes that the request is raised again only after the acknowledge has fallen. The bench therefore holds every request for two cycles and leaves at least one idle cycle before the next one. The bench changes per-core inputs only on the falling clock edge. It raises a core's wait or send-event request for one cycle at a time, and it raises requests from a sleeping core only in the cases that check R9.

// File: rtl/cluster_evt_pkg.sv
package cluster_evt_pkg;

  typedef enum logic [1:0] {
    CS_RUN = 2'd0,
    CS_WFI = 2'd1,
    CS_WFE = 2'd2
  } core_st_e;

  // Next wait state of one core; pend = stored flag or event in this cycle
  function automatic core_st_e core_next(core_st_e st, logic wfi, logic wfe,
                                         logic pend, logic irq, logic lwk,
                                         logic bcast);
    core_st_e nx;
    nx = st;
    case (st)
      CS_RUN: begin
        if (wfi)              nx = CS_WFI;
        else if (wfe && !pend) nx = CS_WFE;
      end
      CS_WFI: if (irq) nx = CS_RUN;
      CS_WFE: if (irq || lwk || bcast) nx = CS_RUN;
      default: nx = CS_RUN;
    endcase
    return nx;
  endfunction

  // Next value of the per-core pending-event flag
  function automatic logic evt_next(core_st_e st, logic evt, logic wfi,
                                    logic wfe, logic bcast);
    logic nx;
    case (st)
      CS_RUN:  nx = (!wfi && wfe && (evt || bcast)) ? 1'b0 : (evt || bcast);
      CS_WFI:  nx = evt || bcast;
      default: nx = evt;  // an event reaching event-wait is used by the wake
    endcase
    return nx;
  endfunction

  function automatic int unsigned cnt_width(int unsigned len);
    return (len < 1) ? 1 : $clog2(len + 1);
  endfunction

endpackage

// File: rtl/core_wait_fsm.sv
module core_wait_fsm
  import cluster_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_req,
  input  logic wfe_req,
  input  logic sev_req,
  input  logic irq_wake,
  input  logic local_wake,
  input  logic hk_any,
  input  logic bcast_evt,
  output logic sev_valid,
  output logic clk_en,
  output logic standby_wfi,
  output logic standby_wfe
);

  core_st_e st_q, st_d;
  logic     evt_q, evt_d;
  logic     running;
  logic     wfi_take, wfe_sleep, wfe_skip, wake_now;

  assign running   = (st_q == CS_RUN);
  assign wfi_take  = running && wfi_req;
  assign wfe_skip  = running && !wfi_req && wfe_req && (evt_q || bcast_evt);
  assign wfe_sleep = running && !wfi_req && wfe_req && !(evt_q || bcast_evt);
  assign wake_now  = !running && (st_d == CS_RUN);

  always_comb begin
    st_d  = core_next(st_q, wfi_req, wfe_req, evt_q || bcast_evt,
                      irq_wake, local_wake, bcast_evt);
    evt_d = evt_next(st_q, evt_q, wfi_req, wfe_req, bcast_evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CS_RUN;
      evt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      evt_q <= evt_d;
    end
  end

  assign sev_valid   = running && sev_req;
  assign clk_en      = running || hk_any;
  assign standby_wfi = (st_q == CS_WFI);
  assign standby_wfe = (st_q == CS_WFE);

  // R2
  wfi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_take |=> standby_wfi);

  // R3
  wfe_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wfe_skip |=> !standby_wfe && !evt_q);

  // R3
  wfe_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wfe_sleep |=> standby_wfe);

  // R6
  wfi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_wfi && !irq_wake) |=> standby_wfi);

  // R5
  wfe_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_wfe && bcast_evt) |=> (!standby_wfe && !evt_q));

  // R4
  hk_keeps_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_wfe && hk_any && !irq_wake && !local_wake && !bcast_evt)
      |=> standby_wfe);

  // R9
  sleep_sev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_wfi || standby_wfe) |-> !sev_valid);

  // R10
  evt_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_evt && (standby_wfi || (running && !wfe_req))) |=> evt_q);

  // R5
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_now |=> clk_en);

endmodule

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen
  import cluster_evt_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);

  localparam int unsigned CNT_W = cnt_width(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (trig)          cnt_q <= CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse = (cnt_q != '0);

  // R7
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse);

  // R7
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> ($past(cnt_q) == CNT_W'(1)));

endmodule

// File: rtl/monclr_hs.sv
module monclr_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ack,
  output logic start
);

  logic ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= req;
  end

  assign ack   = ack_q;
  assign start = req && !ack_q;

  // R8 input rule: request held until acknowledged
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);

  // R8 input rule: new request only once acknowledge has dropped
  req_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && ack) |=> !req);

  // R8
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> !$past(req));

endmodule

// File: rtl/cluster_evt_unit.sv
module cluster_evt_unit
  import cluster_evt_pkg::*;
#(
  parameter int unsigned N_CORES   = 4,
  parameter int unsigned PULSE_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CORES-1:0] wfi_req,
  input  logic [N_CORES-1:0] wfe_req,
  input  logic [N_CORES-1:0] sev_req,
  input  logic [N_CORES-1:0] irq_wake,
  input  logic [N_CORES-1:0] local_wake,
  input  logic [N_CORES-1:0] snoop_req,
  input  logic [N_CORES-1:0] maint_req,
  input  logic [N_CORES-1:0] dbg_req,
  input  logic               event_in,
  input  logic               mon_clr_req,
  output logic [N_CORES-1:0] core_clk_en,
  output logic [N_CORES-1:0] standby_wfi,
  output logic [N_CORES-1:0] standby_wfe,
  output logic               event_out,
  output logic               mon_clr_ack
);

  logic [N_CORES-1:0] sev_valid;
  logic [N_CORES-1:0] hk_any;
  logic               sev_any;
  logic               mc_start;
  logic               bcast_evt;

  assign hk_any    = snoop_req | maint_req | dbg_req;
  assign sev_any   = |sev_valid;
  assign bcast_evt = sev_any || event_in || mc_start;

  monclr_hs u_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (mon_clr_req),
    .ack   (mon_clr_ack),
    .start (mc_start)
  );

  evt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (sev_any),
    .pulse (event_out)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    core_wait_fsm u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .wfi_req     (wfi_req[c]),
      .wfe_req     (wfe_req[c]),
      .sev_req     (sev_req[c]),
      .irq_wake    (irq_wake[c]),
      .local_wake  (local_wake[c]),
      .hk_any      (hk_any[c]),
      .bcast_evt   (bcast_evt),
      .sev_valid   (sev_valid[c]),
      .clk_en      (core_clk_en[c]),
      .standby_wfi (standby_wfi[c]),
      .standby_wfe (standby_wfe[c])
    );
  end

  // R7 other broadcast sources leave the pulse alone
  evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!event_out && !sev_any) |=> !event_out);

  // R2
  one_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_wfi & standby_wfe) == '0);

endmodule

// File: tb/sim_cluster_evt_unit.sv
module sim_cluster_evt_unit;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] wfi_req, wfe_req, sev_req, irq_wake, local_wake;
  logic [N-1:0] snoop_req, maint_req, dbg_req;
  logic event_in, mon_clr_req;
  logic [N-1:0] core_clk_en, standby_wfi, standby_wfe;
  logic event_out, mon_clr_ack;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_evt_unit #(.N_CORES(N), .PULSE_LEN(3)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wfi_req(wfi_req), .wfe_req(wfe_req), .sev_req(sev_req),
    .irq_wake(irq_wake), .local_wake(local_wake),
    .snoop_req(snoop_req), .maint_req(maint_req), .dbg_req(dbg_req),
    .event_in(event_in), .mon_clr_req(mon_clr_req),
    .core_clk_en(core_clk_en), .standby_wfi(standby_wfi),
    .standby_wfe(standby_wfe), .event_out(event_out),
    .mon_clr_ack(mon_clr_ack)
  );

  // {wfi,wfe,sev,irq,lwk,snoop,evin,mreq | exp swfi,swfe,clk_en,eo,ack}
  localparam logic [39:0] VEC [NV] = '{
    {4'b0001,4'b0010,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0, 4'b0001,4'b0010,4'b1100,1'b0,1'b0},
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0011,1'b0,1'b0, 4'b0001,4'b0010,4'b1111,1'b0,1'b0},
    {4'b0000,4'b0000,4'b0100,4'b0000,4'b0000,4'b0000,1'b0,1'b0, 4'b0001,4'b0000,4'b1110,1'b1,1'b0},
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0, 4'b0001,4'b0000,4'b1110,1'b1,1'b0},
    {4'b0000,4'b1000,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0, 4'b0001,4'b0000,4'b1110,1'b1,1'b0},
    {4'b0000,4'b1000,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0, 4'b0001,4'b1000,4'b0110,1'b0,1'b0},
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0, 4'b0001,4'b0000,4'b1110,1'b0,1'b0},
    {4'b0000,4'b0110,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0, 4'b0001,4'b0000,4'b1110,1'b0,1'b0},
    {4'b0000,4'b0110,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0, 4'b0001,4'b0110,4'b1000,1'b0,1'b0},
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b1, 4'b0001,4'b0000,4'b1110,1'b0,1'b1},
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b1, 4'b0001,4'b0000,4'b1110,1'b0,1'b1},
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0, 4'b0001,4'b0000,4'b1110,1'b0,1'b0},
    {4'b0000,4'b0000,4'b0000,4'b0001,4'b0000,4'b0000,1'b0,1'b0, 4'b0000,4'b0000,4'b1111,1'b0,1'b0},
    {4'b0000,4'b0001,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0, 4'b0000,4'b0000,4'b1111,1'b0,1'b0},
    {4'b0000,4'b0001,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0, 4'b0000,4'b0001,4'b1110,1'b0,1'b0},
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0001,4'b0000,1'b0,1'b0, 4'b0000,4'b0000,4'b1111,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wfi_req = '0; wfe_req = '0; sev_req = '0; irq_wake = '0; local_wake = '0;
    snoop_req = '0; maint_req = '0; dbg_req = '0; event_in = 1'b0; mon_clr_req = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // inputs are applied now (falling edge), outputs sampled at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int hi;
    do_reset();
    // R1 reset state
    chk("R1 standby_wfi", 32'(standby_wfi), 32'h0);
    chk("R1 standby_wfe", 32'(standby_wfe), 32'h0);
    chk("R1 clk_en", 32'(core_clk_en), 32'hF);
    chk("R1 event_out", 32'(event_out), 32'h0);
    chk("R1 ack", 32'(mon_clr_ack), 32'h0);

    for (int v = 0; v < NV; v++) begin
      {wfi_req, wfe_req, sev_req, irq_wake, local_wake, snoop_req,
       event_in, mon_clr_req} = VEC[v][39:14];
      step();
      chk("R2 R6 standby_wfi", 32'(standby_wfi), 32'(VEC[v][13:10]));
      chk("R3 R5 standby_wfe", 32'(standby_wfe), 32'(VEC[v][9:6]));
      chk("R4 clk_en", 32'(core_clk_en), 32'(VEC[v][5:2]));
      chk("R7 event_out", 32'(event_out), 32'(VEC[v][1]));
      chk("R8 ack", 32'(mon_clr_ack), 32'(VEC[v][0]));
    end

    // R7 restart: send-events two cycles apart give 5 high cycles
    do_reset();
    hi = 0;
    sev_req = 4'b0001; step(); hi += int'(event_out);
    sev_req = 4'b0000; step(); hi += int'(event_out);
    sev_req = 4'b0010; step(); hi += int'(event_out);
    sev_req = 4'b0000;
    for (int k = 0; k < 4; k++) begin step(); hi += int'(event_out); end
    chk("R7 restart high cycles", 32'(hi), 32'd5);

    // R7 event_in and monitor-clear do not drive event_out
    event_in = 1'b1; step(); event_in = 1'b0;
    chk("R7 event_in no pulse", 32'(event_out), 32'h0);
    mon_clr_req = 1'b1; step();
    chk("R7 mon_clr no pulse", 32'(event_out), 32'h0);
    chk("R8 ack rises", 32'(mon_clr_ack), 32'h1);
    step(); mon_clr_req = 1'b0; step();
    chk("R8 ack falls", 32'(mon_clr_ack), 32'h0);

    // R2 both requests same cycle: interrupt-wait wins
    wfi_req = 4'b0100; wfe_req = 4'b0100; step(); wfi_req = '0; wfe_req = '0;
    chk("R2 wfi priority swfi", 32'(standby_wfi), 32'h4);
    chk("R2 wfi priority swfe", 32'(standby_wfe), 32'h0);
    chk("R2 clk_en low", 32'(core_clk_en), 32'hB);

    // R6 events and local wake leave interrupt-wait untouched
    event_in = 1'b1; local_wake = 4'b0100; step(); event_in = 1'b0; local_wake = '0;
    chk("R6 wfi ignores events", 32'(standby_wfi), 32'h4);
    step();
    chk("R6 wfi stays", 32'(standby_wfi), 32'h4);

    // R9 requests from a sleeping core are ignored
    sev_req = 4'b0100; step(); sev_req = '0;
    chk("R9 sleeping sev", 32'(event_out), 32'h0);
    wfe_req = 4'b0100; step(); wfe_req = '0;
    chk("R9 sleeping wfe swfe", 32'(standby_wfe), 32'h0);
    chk("R9 sleeping wfe swfi", 32'(standby_wfi), 32'h4);

    // R4 maintenance and debug traffic ungate the clock only
    maint_req = 4'b0100; step();
    chk("R4 maint clk_en", 32'(core_clk_en), 32'hF);
    chk("R4 maint swfi", 32'(standby_wfi), 32'h4);
    maint_req = '0; dbg_req = 4'b0100; step();
    chk("R4 dbg clk_en", 32'(core_clk_en), 32'hF);
    dbg_req = '0; step();
    chk("R4 clk_en regated", 32'(core_clk_en), 32'hB);

    // R6 interrupt wakes; R10 event stored during interrupt-wait
    irq_wake = 4'b0100; step(); irq_wake = '0;
    chk("R6 irq wakes", 32'(standby_wfi), 32'h0);
    wfe_req = 4'b0100; step();
    chk("R10 stored event skips wait", 32'(standby_wfe), 32'h0);
    step(); wfe_req = '0;
    chk("R3 second wfe sleeps", 32'(standby_wfe), 32'h4);
    irq_wake = 4'b0100; step(); irq_wake = '0;
    chk("R5 irq wakes wfe", 32'(standby_wfe), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule